// File: doc/BRIEF.md
# Halt Mode Wake-up Controller

This block sequences the standby modes of a small microcontroller core. When the CPU issues a halt instruction, it pulses a strobe together with a 2-bit mode code. The controller stores that code and stops the CPU clock. It also gates each peripheral group's clock according to the stored mode.

While halted, the controller watches the incoming interrupt request, the non-maskable interrupt line and reset, and decides whether the halt ends. A resume pulse tells the CPU to continue. Two qualifiers come with it: whether the waking request is to be serviced, and whether its pending flag must stay set for later.

Leaving the deepest mode (STOP) does not resume at once. A programmable oscillator stabilization countdown runs first, and the CPU stays held until it expires. Reset ends any mode immediately and returns everything to defaults. A release caused by an interrupt keeps the stored configuration.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After reset, cpu_clk_en_o is 1, every periph_clk_en_o bit is 1, and resume_o, osc_wait_o, service_irq_o and keep_pending_o are 0.
- R2: In run state, halt_i with mode_i = 2'b11 (IDLE2), 2'b10 (IDLE1) or 2'b01 (STOP) clears cpu_clk_en_o from the next cycle on. halt_i with mode_i = 2'b00 is ignored and the CPU clock stays on.
- R3: While halted in IDLE2, periph_clk_en_o equals the periph_sel_i value captured with the halt strobe. In IDLE1 and STOP it is all zero.
- R4: While halted in IDLE1 or IDLE2, a request with irq_level_i strictly greater than irq_mask_i ends the halt. In the following cycle resume_o is 1 for exactly one cycle, service_irq_o is 1 and keep_pending_o is 0.
- R5: A request of the normal class (irq_class_i = 0) with irq_level_i less than or equal to irq_mask_i leaves the block halted, and resume_o stays 0.
- R6: nmi_i ends the halt whatever the mask, with service_irq_o = 1 and keep_pending_o = 0. It takes precedence over an always-wake request in the same cycle.
- R7: A request marked always-wake (irq_class_i = 1) ends the halt whatever its level. If its level is at or below the mask, the resume carries service_irq_o = 0 and keep_pending_o = 1. Otherwise it carries service_irq_o = 1 and keep_pending_o = 0.
- R8: A wake from STOP raises osc_wait_o for stab_cnt_i + 1 cycles with the CPU clock off. resume_o follows in the cycle after osc_wait_o falls, and cpu_clk_en_o returns together with it.
- R9: During the stabilization wait, interrupt and NMI inputs have no effect on its length.
- R10: While halted, a further halt_i strobe does not change the stored mode or peripheral selection.
- R11: Asserting rst_ni during a halt immediately restores the R1 state.
- R12: Changes on periph_sel_i while halted have no effect on periph_clk_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Halt instruction strobe |
| mode_i | input | 2 | Mode code: 00 run, 01 STOP, 10 IDLE1, 11 IDLE2 |
| periph_sel_i | input | N_PERIPH | Per-group keep-running select for IDLE2 |
| stab_cnt_i | input | CNT_W | Oscillator stabilization count |
| irq_valid_i | input | 1 | Maskable interrupt request present |
| irq_level_i | input | 3 | Request priority level |
| irq_class_i | input | 1 | 1 = always-wake source |
| irq_mask_i | input | 3 | Current interrupt mask level |
| nmi_i | input | 1 | Non-maskable interrupt |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | N_PERIPH | Peripheral group clock enables |
| osc_wait_o | output | 1 | Oscillator stabilization in progress |
| resume_o | output | 1 | One-cycle resume pulse |
| service_irq_o | output | 1 | With resume: service the waking request |
| keep_pending_o | output | 1 | With resume: leave request flag set |

## Verification
The assertions assume that the interrupt inputs describe a single request per cycle. They also assume that halt_i is raised only while the CPU clock is running or is otherwise tolerated. The bench holds every interrupt input steady across one clock edge and clears them after each wake. It never drives an NMI and a strobe in the same cycle, except where R10 is tested on purpose. It sweeps all level, mask, class and NMI combinations for both idle modes, and several stabilization counts for STOP.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_STOP  = 2'b01,
    MODE_IDLE1 = 2'b10,
    MODE_IDLE2 = 2'b11
  } hwc_mode_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_HALT = 2'b01,
    ST_OSC  = 2'b10
  } hwc_state_e;

  localparam int unsigned LVL_W = 3;
endpackage

// File: rtl/hwc_wake_decide.sv
module hwc_wake_decide
  import hwc_pkg::*;
(
  input  logic             irq_valid_i,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic             irq_class_i,
  input  logic [LVL_W-1:0] irq_mask_i,
  input  logic             nmi_i,
  output logic             wake_o,
  output logic             svc_o,
  output logic             keep_o
);
  logic above_mask;
  assign above_mask = irq_valid_i && (irq_level_i > irq_mask_i);

  // priority: nmi > always-wake class > level-qualified
  always_comb begin
    wake_o = 1'b0;
    svc_o  = 1'b0;
    keep_o = 1'b0;
    if (nmi_i) begin
      wake_o = 1'b1;
      svc_o  = 1'b1;
    end else if (irq_valid_i && irq_class_i) begin
      wake_o = 1'b1;
      svc_o  = above_mask;
      keep_o = !above_mask;
    end else if (above_mask) begin
      wake_o = 1'b1;
      svc_o  = 1'b1;
    end
  end
endmodule

// File: rtl/hwc_osc_timer.sv
module hwc_osc_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/hwc_clk_gate.sv
module hwc_clk_gate
  import hwc_pkg::*;
#(
  parameter int unsigned N_PERIPH = 4
) (
  input  hwc_state_e           state_i,
  input  hwc_mode_e            mode_i,
  input  logic [N_PERIPH-1:0]  sel_i,
  output logic                 cpu_en_o,
  output logic [N_PERIPH-1:0]  periph_en_o
);
  logic running, idle2;
  assign running  = (state_i == ST_RUN);
  assign idle2    = (state_i == ST_HALT) && (mode_i == MODE_IDLE2);
  assign cpu_en_o = running;

  for (genvar g = 0; g < N_PERIPH; g++) begin : g_periph
    assign periph_en_o[g] = running || (idle2 && sel_i[g]);
  end
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import hwc_pkg::*;
#(
  parameter int unsigned N_PERIPH = 4,
  parameter int unsigned CNT_W    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                halt_i,
  input  logic [1:0]          mode_i,
  input  logic [N_PERIPH-1:0] periph_sel_i,
  input  logic [CNT_W-1:0]    stab_cnt_i,
  input  logic                irq_valid_i,
  input  logic [2:0]          irq_level_i,
  input  logic                irq_class_i,
  input  logic [2:0]          irq_mask_i,
  input  logic                nmi_i,
  output logic                cpu_clk_en_o,
  output logic [N_PERIPH-1:0] periph_clk_en_o,
  output logic                osc_wait_o,
  output logic                resume_o,
  output logic                service_irq_o,
  output logic                keep_pending_o
);
  hwc_state_e          state_q;
  hwc_mode_e           mode_q;
  logic [N_PERIPH-1:0] sel_q;
  logic                resume_q, svc_q, keep_q;
  logic                wake, wake_svc, wake_keep, osc_done;
  logic                halt_req, wake_idle, wake_stop;

  hwc_wake_decide u_decide (
    .irq_valid_i (irq_valid_i),
    .irq_level_i (irq_level_i),
    .irq_class_i (irq_class_i),
    .irq_mask_i  (irq_mask_i),
    .nmi_i       (nmi_i),
    .wake_o      (wake),
    .svc_o       (wake_svc),
    .keep_o      (wake_keep)
  );

  assign halt_req  = (state_q == ST_RUN) && halt_i && (mode_i != MODE_RUN);
  assign wake_idle = (state_q == ST_HALT) && wake && (mode_q != MODE_STOP);
  assign wake_stop = (state_q == ST_HALT) && wake && (mode_q == MODE_STOP);

  hwc_osc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wake_stop),
    .load_val_i (stab_cnt_i),
    .run_i      (state_q == ST_OSC),
    .done_o     (osc_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      mode_q   <= MODE_RUN;
      sel_q    <= '0;
      resume_q <= 1'b0;
      svc_q    <= 1'b0;
      keep_q   <= 1'b0;
    end else begin
      resume_q <= 1'b0;
      unique case (state_q)
        ST_RUN: if (halt_req) begin
          state_q <= ST_HALT;
          mode_q  <= hwc_mode_e'(mode_i);
          sel_q   <= periph_sel_i;
        end
        ST_HALT: if (wake) begin
          svc_q  <= wake_svc;
          keep_q <= wake_keep;
          if (wake_idle) begin
            state_q  <= ST_RUN;
            resume_q <= 1'b1;
          end else begin
            state_q  <= ST_OSC;
          end
        end
        ST_OSC: if (osc_done) begin
          state_q  <= ST_RUN;
          resume_q <= 1'b1;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  hwc_clk_gate #(.N_PERIPH(N_PERIPH)) u_gate (
    .state_i     (state_q),
    .mode_i      (mode_q),
    .sel_i       (sel_q),
    .cpu_en_o    (cpu_clk_en_o),
    .periph_en_o (periph_clk_en_o)
  );

  assign osc_wait_o     = (state_q == ST_OSC);
  assign resume_o       = resume_q;
  assign service_irq_o  = resume_q && svc_q;
  assign keep_pending_o = resume_q && keep_q;
endmodule

// File: rtl/hwc_checker.sv
module hwc_checker #(
  parameter int unsigned N_PERIPH = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                halt_i,
  input logic [1:0]          mode_i,
  input logic                irq_valid_i,
  input logic [2:0]          irq_level_i,
  input logic                irq_class_i,
  input logic [2:0]          irq_mask_i,
  input logic                nmi_i,
  input logic                cpu_clk_en_o,
  input logic [N_PERIPH-1:0] periph_clk_en_o,
  input logic                osc_wait_o,
  input logic                resume_o,
  input logic                service_irq_o,
  input logic                keep_pending_o
);
  logic halted;
  assign halted = !cpu_clk_en_o && !osc_wait_o;

  a_r2_mode00_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && halt_i && mode_i == 2'b00) |=> cpu_clk_en_o);

  a_r2_halt_stops_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && halt_i && mode_i != 2'b00) |=> !cpu_clk_en_o);

  a_r4_resume_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);

  a_r5_low_level_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted && irq_valid_i && !irq_class_i && !nmi_i && irq_level_i <= irq_mask_i)
      |=> !resume_o);

  a_r6_nmi_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted && nmi_i) |=> (osc_wait_o || (resume_o && service_irq_o && !keep_pending_o)));

  a_r7_keep_without_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keep_pending_o |-> (resume_o && !service_irq_o));

  a_r8_cpu_held_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_wait_o |-> (!cpu_clk_en_o && periph_clk_en_o == '0));
endmodule

bind halt_wake_ctrl hwc_checker #(.N_PERIPH(N_PERIPH)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .halt_i          (halt_i),
  .mode_i          (mode_i),
  .irq_valid_i     (irq_valid_i),
  .irq_level_i     (irq_level_i),
  .irq_class_i     (irq_class_i),
  .irq_mask_i      (irq_mask_i),
  .nmi_i           (nmi_i),
  .cpu_clk_en_o    (cpu_clk_en_o),
  .periph_clk_en_o (periph_clk_en_o),
  .osc_wait_o      (osc_wait_o),
  .resume_o        (resume_o),
  .service_irq_o   (service_irq_o),
  .keep_pending_o  (keep_pending_o)
);

// File: tb/sim_halt_wake_ctrl.sv
module sim_halt_wake_ctrl;
  localparam int unsigned NP = 4;
  localparam int unsigned CW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          halt_i = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [NP-1:0] periph_sel_i = '0;
  logic [CW-1:0] stab_cnt_i = '0;
  logic          irq_valid_i = 1'b0;
  logic [2:0]    irq_level_i = '0;
  logic          irq_class_i = 1'b0;
  logic [2:0]    irq_mask_i = '0;
  logic          nmi_i = 1'b0;
  logic          cpu_clk_en_o, osc_wait_o, resume_o, service_irq_o, keep_pending_o;
  logic [NP-1:0] periph_clk_en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  halt_wake_ctrl #(.N_PERIPH(NP), .CNT_W(CW)) u0 (.*);

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_irq();
    irq_valid_i = 1'b0; irq_class_i = 1'b0; nmi_i = 1'b0;
    irq_level_i = '0;   irq_mask_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 cpu_en", cpu_clk_en_o, 1);
    chk("R1 periph", periph_clk_en_o, {NP{1'b1}});
    chk("R1 resume", resume_o, 0);
    chk("R1 osc", osc_wait_o, 0);
    rst_ni = 1'b1;
    tick();
    chk("R1 cpu_en after release", cpu_clk_en_o, 1);
    chk("R1 svc/keep", {service_irq_o, keep_pending_o}, 0);

    // R2: mode 00 strobe ignored
    halt_i = 1'b1; mode_i = 2'b00;
    tick(); halt_i = 1'b0;
    chk("R2 mode00 ignored", cpu_clk_en_o, 1);
    tick();

    // Exhaustive idle sweep: R2 R3 R4 R5 R6 R7
    for (int m = 2; m <= 3; m++) begin
      for (int lv = 0; lv < 8; lv++) begin
        for (int mk = 0; mk < 8; mk++) begin
          for (int cl = 0; cl < 2; cl++) begin
            for (int nm = 0; nm < 2; nm++) begin
              logic [NP-1:0] sel;
              bit above, wk, sv, kp;
              sel   = NP'(lv + mk);
              above = (lv > mk);
              wk    = nm[0] || cl[0] || above;
              sv    = nm[0] || above;
              kp    = !nm[0] && cl[0] && !above;
              halt_i = 1'b1; mode_i = m[1:0]; periph_sel_i = sel;
              tick(); halt_i = 1'b0;
              chk("R2 cpu off", cpu_clk_en_o, 0);
              chk("R3 periph", periph_clk_en_o, (m == 3) ? sel : '0);
              irq_valid_i = 1'b1; irq_level_i = lv[2:0]; irq_mask_i = mk[2:0];
              irq_class_i = cl[0]; nmi_i = nm[0];
              tick();
              chk(nm ? "R6 resume" : (cl ? "R7 resume" : (above ? "R4 resume" : "R5 no resume")),
                  resume_o, wk);
              chk(nm ? "R6 service" : (cl ? "R7 service" : "R4 service"),
                  service_irq_o, wk && sv);
              chk(nm ? "R6 keep" : "R7 keep", keep_pending_o, wk && kp);
              clear_irq();
              if (wk) begin
                chk("R4 cpu back", cpu_clk_en_o, 1);
                tick();
                chk("R4 one-cycle pulse", resume_o, 0);
              end else begin
                chk("R5 still halted", cpu_clk_en_o, 0);
                nmi_i = 1'b1;
                tick(); nmi_i = 1'b0;
                tick();
              end
            end
          end
        end
      end
    end

    // STOP: R3 R8 R9
    for (int t = 0; t < 5; t++) begin
      int n, cnt;
      n = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 3 : (t == 3) ? 17 : 40;
      stab_cnt_i = CW'(n);
      halt_i = 1'b1; mode_i = 2'b01; periph_sel_i = '1;
      tick(); halt_i = 1'b0;
      chk("R3 stop periph", periph_clk_en_o, 0);
      irq_valid_i = 1'b1; irq_level_i = 3'd7; irq_mask_i = 3'd0;
      tick(); clear_irq();
      chk("R8 osc start", osc_wait_o, 1);
      chk("R8 no early resume", resume_o, 0);
      cnt = 1;
      for (int k = 0; k < 100; k++) begin
        if (k == 0 || k == 2) nmi_i = 1'b1;
        else nmi_i = 1'b0;
        if (k == 1) begin irq_valid_i = 1'b1; irq_level_i = 3'd7; end
        else irq_valid_i = 1'b0;
        tick();
        if (resume_o) break;
        if (osc_wait_o) cnt++;
        chk("R8 cpu held", cpu_clk_en_o, 0);
      end
      clear_irq();
      chk("R9 wait length", cnt, n + 1);
      chk("R8 resume", resume_o, 1);
      chk("R8 osc done", osc_wait_o, 0);
      chk("R8 cpu back", cpu_clk_en_o, 1);
      tick();
    end

    // R10 R12: stored selection and mode survive input changes while halted
    halt_i = 1'b1; mode_i = 2'b11; periph_sel_i = 4'b0101;
    tick(); halt_i = 1'b0; periph_sel_i = 4'b1010;
    tick();
    chk("R12 sel held", periph_clk_en_o, 4'b0101);
    halt_i = 1'b1; mode_i = 2'b01;
    tick(); halt_i = 1'b0;
    chk("R10 mode held", periph_clk_en_o, 4'b0101);
    irq_valid_i = 1'b1; irq_level_i = 3'd5; irq_mask_i = 3'd2;
    tick(); clear_irq();
    chk("R10 idle wake no osc", {resume_o, osc_wait_o}, 2'b10);
    tick();

    // R11: reset during halt
    halt_i = 1'b1; mode_i = 2'b10;
    tick(); halt_i = 1'b0;
    chk("R11 halted", cpu_clk_en_o, 0);
    rst_ni = 1'b0;
    #1;
    chk("R11 cpu_en", cpu_clk_en_o, 1);
    chk("R11 periph", periph_clk_en_o, {NP{1'b1}});
    chk("R11 osc", osc_wait_o, 0);
    tick(); rst_ni = 1'b1;
    tick();
    chk("R11 running", cpu_clk_en_o, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule